// File: doc/BRIEF.md
# Misaligned Word Load Combiner

This block sits between a load unit and a word-organized memory that can only be read at word boundaries. The load unit presents a byte address, a request strobe and a byte-order select. When the address falls on a word boundary, the block issues a single memory read. When it does not, the block reads the row that holds the first byte and then the row after it. It then selects the four requested bytes from the two rows and packs them into one result word in the chosen byte order.

The memory port is a plain read strobe with an address. Data is returned on the cycle after the strobe. Each result is announced by a one-cycle valid pulse. A status flag accompanies the result and tells whether the access needed two reads. The result word and the flag stay unchanged until the next result, so a testbench can count split accesses. While a load is in flight the block reports busy, and it takes no new request.

Top module: `lc_unaligned_load`

## Requirements
- R1: After reset, `rsp_valid`, `mem_rd_en` and `busy` are all low.
- R2: A request accepted at an address whose two low bits are zero causes exactly one memory read, in the cycle after acceptance. `rsp_valid` goes high on the second rising edge after the accepting edge.
- R3: A request accepted at any other address causes exactly two memory reads, in the two cycles after acceptance. `rsp_valid` goes high on the third rising edge after the accepting edge.
- R4: The first read address is the request address with its two low bits cleared. The second read address is the first plus 4, wrapping modulo 2^32.
- R5: Each memory row holds the byte at row offset k in data bits [8k+7:8k]. With `req_big_endian` low, the byte at request address + i is placed in result bits [8i+7:8i], for i = 0..3.
- R6: With `req_big_endian` high, the byte at request address + i is placed in result bits [8(3-i)+7:8(3-i)].
- R7: A request is accepted only on a rising edge where `busy` is low. `busy` is high from the cycle after acceptance up to, but not including, the cycle in which `rsp_valid` is high. A request held high while `busy` is high causes no read and no extra response.
- R8: `rsp_valid` is high for one cycle per load. `rsp_split` is set alongside it to 1 for a two-read load and to 0 otherwise. `rsp_split` and `rsp_data` hold their values until the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request strobe |
| req_addr | input | 32 | Byte address of the word to load |
| req_big_endian | input | 1 | 1: lowest address goes to the most significant byte |
| busy | output | 1 | A load is in flight and requests are ignored |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Word-aligned memory read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | One-cycle pulse marking a finished load |
| rsp_data | output | 32 | Assembled result word |
| rsp_split | output | 1 | The last finished load needed two reads |

## Verification
Each load is checked in every cycle from its accepting edge to the cycle after its result. For an aligned address, a read strobe is expected in the first cycle only, and the result on the second edge. For a misaligned address, strobes are expected at the base row and then the next row, and the result on the third edge. The bench drives inputs and samples outputs on falling edges, so each expected value is compared in exactly the cycle the register chain places it. Expected words come from a behavioural byte-addressed view of the memory model, and loads are repeated with a request held high while the block is busy.

// File: rtl/lc_pkg.sv
package lc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUE0 = 2'd1,
      ST_ISSUE1 = 2'd2,
      ST_DRAIN  = 2'd3
   } lc_state_e;
endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
   import lc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   localparam int OFF_W     = $clog2(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_big,
   output logic              busy,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   output logic [OFF_W-1:0]  off,
   output logic              big,
   output logic              split,
   output logic              latch_first,
   output logic              finish
);
   lc_state_e         state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic              big_q;
   logic [ADDR_W-1:0] row_base;
   logic              accept;

   assign accept   = (state_q == ST_IDLE) && req_valid;
   assign off      = addr_q[OFF_W-1:0];
   assign big      = big_q;
   assign split    = (off != '0);
   assign row_base = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept) state_d = ST_ISSUE0;
         ST_ISSUE0: state_d = split ? ST_ISSUE1 : ST_DRAIN;
         ST_ISSUE1: state_d = ST_DRAIN;
         ST_DRAIN:  state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         big_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q <= req_addr;
            big_q  <= req_big;
         end
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign mem_rd_en   = (state_q == ST_ISSUE0) || (state_q == ST_ISSUE1);
   assign mem_rd_addr = (state_q == ST_ISSUE1) ? row_base + ADDR_W'(WORD_BYTES) : row_base;
   assign latch_first = (state_q == ST_ISSUE1);
   assign finish      = (state_q == ST_DRAIN);

   // R2: an aligned load strobes memory once only
   a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ISSUE0 && !split) |=> !mem_rd_en);

   // R3, R4: a split load reads the following row next
   a_r3_next_row: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ISSUE0 && split) |=>
         (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(WORD_BYTES)));

   // R7: an idle unit takes a request and turns busy
   a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> (busy && mem_rd_en));

   // R7: a request seen while busy leaves the captured address alone
   a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q));
endmodule

// File: rtl/lc_merge.sv
module lc_merge #(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 4,
   localparam int OFF_W     = $clog2(WORD_BYTES),
   localparam int WORD_W    = BYTE_W * WORD_BYTES,
   localparam int IDX_W     = OFF_W + 1
) (
   input  logic [OFF_W-1:0]  off,
   input  logic              big,
   input  logic [WORD_W-1:0] row_lo,
   input  logic [WORD_W-1:0] row_hi,
   output logic [WORD_W-1:0] word_out
);
   logic [BYTE_W-1:0] window [2*WORD_BYTES];
   logic [BYTE_W-1:0] pick   [WORD_BYTES];

   for (genvar k = 0; k < WORD_BYTES; k++) begin : g_window
      assign window[k]              = row_lo[k*BYTE_W +: BYTE_W];
      assign window[k + WORD_BYTES] = row_hi[k*BYTE_W +: BYTE_W];
   end

   for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
      logic [IDX_W-1:0] idx;
      assign idx     = {1'b0, off} + IDX_W'(i);
      assign pick[i] = window[idx];
      assign word_out[i*BYTE_W +: BYTE_W] = big ? pick[WORD_BYTES-1-i] : pick[i];
   end
endmodule

// File: rtl/lc_unaligned_load.sv
module lc_unaligned_load #(
   parameter int ADDR_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 4,
   localparam int WORD_W    = BYTE_W * WORD_BYTES,
   localparam int OFF_W     = $clog2(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_big_endian,
   output logic              busy,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_data,
   output logic              rsp_split
);
   if (WORD_BYTES < 2 || (1 << OFF_W) != WORD_BYTES) begin : g_bad_word
      $error("WORD_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the byte offset width");
   end

   logic [OFF_W-1:0]  off;
   logic              big, split, latch_first, finish;
   logic [WORD_W-1:0] first_q, row_lo, merged;

   lc_ctrl #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_big(req_big_endian), .busy(busy), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .off(off), .big(big), .split(split),
      .latch_first(latch_first), .finish(finish)
   );

   assign row_lo = split ? first_q : mem_rd_data;

   lc_merge #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_merge (
      .off(off), .big(big), .row_lo(row_lo), .row_hi(mem_rd_data), .word_out(merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_split <= 1'b0;
      end else begin
         if (latch_first) first_q <= mem_rd_data;
         rsp_valid <= finish;
         if (finish) begin
            rsp_data  <= merged;
            rsp_split <= split;
         end
      end
   end

   logic [WORD_W-1:0] rd_swapped;
   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_swap
      assign rd_swapped[b*BYTE_W +: BYTE_W] = mem_rd_data[(WORD_BYTES-1-b)*BYTE_W +: BYTE_W];
   end

   // R5: aligned little-endian load returns the row unchanged
   a_r5_le_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !split && !big) |=> (rsp_data == $past(mem_rd_data)));

   // R6: aligned big-endian load returns the row byte-reversed
   a_r6_be_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !split && big) |=> (rsp_data == $past(rd_swapped)));

   // R8: response is a single-cycle pulse
   a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R8: result and status hold between responses
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !finish |=> ($stable(rsp_split) && $stable(rsp_data)));

   // R7: no response is produced while a load is still in flight
   a_r7_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy);
endmodule

// File: tb/lc_unaligned_load_bench.sv
module lc_unaligned_load_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_big_endian = 1'b0;
   logic        busy, mem_rd_en, rsp_valid, rsp_split;
   logic [31:0] mem_rd_addr, rsp_data;
   logic [31:0] mem_rd_data = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   lc_unaligned_load u_lc_unaligned_load (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_big_endian(req_big_endian), .busy(busy), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_split(rsp_split)
   );

   function automatic logic [31:0] row_fn(input logic [31:0] row);
      return (row * 32'h9E3779B1) ^ 32'h5A3C96E1;
   endfunction

   function automatic logic [7:0] byte_at(input logic [31:0] a);
      logic [31:0] r;
      r = row_fn({a[31:2], 2'b00});
      return r[8*a[1:0] +: 8];
   endfunction

   function automatic logic [31:0] expect_word(input logic [31:0] a, input logic be);
      logic [31:0] w;
      for (int i = 0; i < 4; i++) begin
         if (be) w[8*(3-i) +: 8] = byte_at(a + 32'(i));
         else    w[8*i +: 8]     = byte_at(a + 32'(i));
      end
      return w;
   endfunction

   // memory model: one-cycle read latency
   always @(posedge clk) if (mem_rd_en) mem_rd_data <= row_fn(mem_rd_addr);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_load(input logic [31:0] a, input logic be, input logic poke);
      logic        spl;
      logic [31:0] row0, exp;
      spl  = (a[1:0] != 2'b00);
      row0 = {a[31:2], 2'b00};
      exp  = expect_word(a, be);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_big_endian = be;
      @(negedge clk);                                  // cycle after accepting edge
      if (poke) begin req_addr = a ^ 32'h40; req_big_endian = ~be; end
      else req_valid = 1'b0;
      chk(busy === 1'b1, "R7 busy", 32'(busy), 32'd1);
      chk(mem_rd_en === 1'b1, "R2/R3 first read", 32'(mem_rd_en), 32'd1);
      chk(mem_rd_addr === row0, "R4 first row", mem_rd_addr, row0);
      chk(rsp_valid === 1'b0, "R2 early rsp", 32'(rsp_valid), 32'd0);
      @(negedge clk);
      if (spl) begin
         chk(mem_rd_en === 1'b1, "R3 second read", 32'(mem_rd_en), 32'd1);
         chk(mem_rd_addr === row0 + 32'd4, "R4 second row", mem_rd_addr, row0 + 32'd4);
         chk(busy === 1'b1, "R7 busy", 32'(busy), 32'd1);
         @(negedge clk);
         req_valid = 1'b0;
         chk(mem_rd_en === 1'b0, "R3 only two reads", 32'(mem_rd_en), 32'd0);
      end else begin
         req_valid = 1'b0;
         chk(mem_rd_en === 1'b0, "R2 only one read", 32'(mem_rd_en), 32'd0);
      end
      chk(busy === 1'b1, "R7 busy till result", 32'(busy), 32'd1);
      chk(rsp_valid === 1'b0, "R2/R3 early rsp", 32'(rsp_valid), 32'd0);
      @(negedge clk);                                  // response cycle
      chk(rsp_valid === 1'b1, spl ? "R3 rsp timing" : "R2 rsp timing", 32'(rsp_valid), 32'd1);
      chk(busy === 1'b0, "R7 idle at rsp", 32'(busy), 32'd0);
      chk(rsp_data === exp, be ? "R6 big-endian data" : "R5 little-endian data", rsp_data, exp);
      chk(rsp_split === spl, "R8 split flag", 32'(rsp_split), 32'(spl));
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R8 single pulse", 32'(rsp_valid), 32'd0);
      chk(mem_rd_en === 1'b0, "R7 ignored request", 32'(mem_rd_en), 32'd0);
      chk(rsp_data === exp, "R8 data hold", rsp_data, exp);
      chk(rsp_split === spl, "R8 split hold", 32'(rsp_split), 32'(spl));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(rsp_valid === 1'b0, "R1 rsp_valid reset", 32'(rsp_valid), 32'd0);
      chk(mem_rd_en === 1'b0, "R1 mem_rd_en reset", 32'(mem_rd_en), 32'd0);
      chk(busy === 1'b0, "R1 busy reset", 32'(busy), 32'd0);
      rst_n = 1'b1;
      for (int o = 0; o < 4; o++) begin
         do_load(32'h0000_1000 + 32'(o), 1'b0, 1'b0);
         do_load(32'h0000_2340 + 32'(o), 1'b1, 1'b0);
         do_load(32'h8765_4320 + 32'(o), 1'b0, 1'b1);
         do_load(32'h1357_9BD0 + 32'(o), 1'b1, 1'b1);
      end
      do_load(32'hFFFF_FFFE, 1'b0, 1'b0);
      do_load(32'hFFFF_FFFD, 1'b1, 1'b1);
      do_load(32'hFFFF_FFFC, 1'b1, 1'b0);
      do_load(32'h0000_0003, 1'b0, 1'b1);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule